// File: doc/BRIEF.md
# Aliased Channel Control Register Bank

This block is the software-visible control and status bank of a four-channel accelerator. A host reaches it over a plain 32-bit read/write bus with a 12-bit byte address. It holds one global control word, one global status word, a channel-control word, and four registers for each channel: command pointer, semaphore, channel status and options. Every register answers at its base offset and at three alias offsets. Through these aliases software can set, clear or flip single bits in one bus write, with no read-modify-write sequence.

The bank drives the per-channel enable and priority lines, the soft-reset and clock-gate lines, three mode lines and one interrupt line per channel. Channel engines report into the bank through input strobes: a completion strobe, a status-event strobe with a bit vector, and a semaphore-decrement strobe. Capability, ready, active-channel and key-ready information comes in as levels and reads back as read-only fields.

Top module: `chreg_bank`

## Requirements
- R1: After the reset input is released, the control word reads 0xF000_0000. Bits 31 (soft reset) and 30 (clock gate) are set, and bits 29 and 28 (capabilities, both present by default) are set. Every other stored field reads zero, and soft_rst_o and clk_gate_o are 1.
- R2: Address bits 3:2 select the access type for the register at the base offset with those bits cleared: 00 replaces the writable bits, 01 ORs in the written bits, 10 clears the written bits, 11 XORs the written bits.
- R3: A read at any of the four alias offsets returns the register value. A read of an unmapped offset returns zero, and a write to an unmapped offset changes no register.
- R4: Read-only fields ignore every write type. Control bits 29 and 28 come from parameters. In the status word, bit 28 follows key_ready_i, bits 27:24 follow active_i and bits 19:16 follow ready_i. Unnamed bits read zero.
- R5: While control bit 31 is 1, every register except control bits 31 and 30 is forced to its reset value from the next edge on, and writes to those registers are lost. Clearing bits 31 and 30 through the clear alias (0x008, data 0xC000_0000) releases the bank.
- R6: A pulse on done_i[n] sets status-word bit n, which stays set until software clears it. If a completion and a software clear of the same bit arrive in the same cycle, the bit stays set.
- R7: irq_o[n] is high exactly while status bit n and control bit n are both 1.
- R8: The channel-control word at 0x020 stores enables in bits 3:0 (driving ch_en_o), high-priority marks in bits 11:8 (driving ch_prio_o) and a merge flag in bit 16. All other bits read zero.
- R9: Channel n's registers sit at 0x100 + n×0x40 plus 0x00 (32-bit command pointer), 0x10 (semaphore, bits 7:0), 0x20 (channel status, writable bits 23:16 and 6:1) and 0x30 (32-bit options). The global words sit at 0x000 (control), 0x010 (status) and 0x020 (channel control).
- R10: A pulse on evt_we_i[n] ORs evt_bits_i for that channel, masked to bits 23:16 and 6:1, into that channel's status register.
- R11: A pulse on sem_dec_i[n] decrements channel n's semaphore and stops at zero. In a cycle that also holds a software write to that semaphore, the decrement applies to the written result.
- R12: clk_gate_o follows control bit 30, soft_rst_o follows bit 31, and mode_o follows bits 23:21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| done_i | input | 4 | Per-channel completion strobes |
| ready_i | input | 4 | Per-channel ready levels |
| active_i | input | 4 | Currently active channel field |
| key_ready_i | input | 1 | Key available level |
| evt_we_i | input | 4 | Per-channel status event strobes |
| evt_bits_i | input | 128 | Status event bits, 32 per channel, channel n at [32n+31:32n] |
| sem_dec_i | input | 4 | Per-channel semaphore decrement strobes |
| irq_o | output | 4 | Per-channel interrupt lines |
| ch_en_o | output | 4 | Channel enables |
| ch_prio_o | output | 4 | Channel high-priority marks |
| soft_rst_o | output | 1 | Soft reset state |
| clk_gate_o | output | 1 | Clock gate state |
| mode_o | output | 3 | Mode enables |

## Verification
The hardest situations to reach from the ports are collisions: a completion strobe in the same cycle as a software clear of that flag, and a semaphore decrement in the same cycle as a software write to that semaphore. The bench drives the bus write and the strobe in the same cycle for both cases. It also sweeps all nineteen registers through all four access types with several bit patterns, reads each result back at all four aliases, and walks every unmapped word of the address space. Soft reset is reached by setting bit 31 through the set alias, with live values stored in the channel registers beforehand.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } alias_op_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEM_W  = 8;

  // register kind within a channel block, from address bits 5:4
  localparam logic [1:0] KIND_PTR = 2'd0;
  localparam logic [1:0] KIND_SEM = 2'd1;
  localparam logic [1:0] KIND_STS = 2'd2;
  localparam logic [1:0] KIND_OPT = 2'd3;

  // control word fields
  localparam int unsigned CTRL_SRST_BIT = 31;
  localparam int unsigned CTRL_GATE_BIT = 30;
  localparam int unsigned CTRL_CAPA_BIT = 29;
  localparam int unsigned CTRL_CAPB_BIT = 28;
  localparam int unsigned CTRL_MODE_LO  = 21;
  localparam logic [31:0] CTRL_FIX_WMASK = 32'hC0E0_0000;
  localparam logic [31:0] CTRL_KEEP_SRST = 32'hC000_0000;

  // status word fields
  localparam int unsigned STAT_KEY_BIT = 28;
  localparam int unsigned STAT_ACT_LO  = 24;
  localparam int unsigned STAT_RDY_LO  = 16;

  // channel control fields
  localparam int unsigned CHC_PRIO_LO   = 8;
  localparam int unsigned CHC_MERGE_BIT = 16;

  // channel status writable bits
  localparam logic [31:0] CST_WMASK = 32'h00FF_007E;

  function automatic logic [31:0] alias_apply(
    input alias_op_e   op,
    input logic [31:0] cur,
    input logic [31:0] wd,
    input logic [31:0] msk
  );
    logic [31:0] res;
    unique case (op)
      OP_WR:   res = wd;
      OP_SET:  res = cur | wd;
      OP_CLR:  res = cur & ~wd;
      default: res = cur ^ wd;
    endcase
    return (res & msk) | (cur & ~msk);
  endfunction

endpackage

// File: rtl/chreg_decode.sv
module chreg_decode
  import chreg_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output alias_op_e         op_o,
  output logic              hit_ctrl_o,
  output logic              hit_stat_o,
  output logic              hit_chc_o,
  output logic [NUM_CH-1:0] hit_ch_o,
  output logic [1:0]        kind_o,
  output logic              hit_any_o
);

  logic [ADDR_W-5:0] slot;
  logic [ADDR_W-9:0] page;
  logic              ch_region;
  logic [1:0]        unused_lo;

  assign slot      = addr_i[ADDR_W-1:4];
  assign page      = addr_i[ADDR_W-1:8];
  assign unused_lo = addr_i[1:0];
  assign op_o      = alias_op_e'(addr_i[3:2]);
  assign kind_o    = addr_i[5:4];

  assign hit_ctrl_o = (slot == (ADDR_W-4)'(0));
  assign hit_stat_o = (slot == (ADDR_W-4)'(1));
  assign hit_chc_o  = (slot == (ADDR_W-4)'(2));
  assign ch_region  = (page == (ADDR_W-8)'(1));

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch_hit
    assign hit_ch_o[gi] = ch_region && (addr_i[7:6] == 2'(gi));
  end

  assign hit_any_o = hit_ctrl_o | hit_stat_o | hit_chc_o | (|hit_ch_o);

endmodule

// File: rtl/chreg_global.sv
module chreg_global
  import chreg_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter bit          CAP_CIPHER = 1'b1,
  parameter bit          CAP_HASH   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic              wr_stat_i,
  input  logic              wr_chc_i,
  input  alias_op_e         op_i,
  input  logic [31:0]       wdata_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] ready_i,
  input  logic [NUM_CH-1:0] active_i,
  input  logic              key_ready_i,
  output logic [31:0]       ctrl_rd_o,
  output logic [31:0]       stat_rd_o,
  output logic [31:0]       chc_rd_o,
  output logic              srst_o,
  output logic              gate_o,
  output logic [2:0]        mode_o,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic [NUM_CH-1:0] ch_prio_o,
  output logic [NUM_CH-1:0] irq_o
);

  localparam logic [31:0] CH_MASK    = (32'd1 << NUM_CH) - 32'd1;
  localparam logic [31:0] CTRL_WMASK = CTRL_FIX_WMASK | CH_MASK;
  localparam logic [31:0] CHC_WMASK  = (32'd1 << CHC_MERGE_BIT) | (CH_MASK << CHC_PRIO_LO) | CH_MASK;
  localparam logic [31:0] CTRL_RST   = CTRL_KEEP_SRST;
  localparam logic [31:0] CAP_BITS   = (32'(CAP_CIPHER) << CTRL_CAPA_BIT) | (32'(CAP_HASH) << CTRL_CAPB_BIT);

  logic [31:0]       ctrl_q, ctrl_d;
  logic [31:0]       chc_q, chc_d;
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic              ctrl_en, chc_en, flag_en;
  logic              srst;

  assign srst = ctrl_q[CTRL_SRST_BIT];

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl_i) ctrl_d = alias_apply(op_i, ctrl_q, wdata_i, CTRL_WMASK);
    if (srst)      ctrl_d = ctrl_d & CTRL_KEEP_SRST;

    chc_d = chc_q;
    if (wr_chc_i) chc_d = alias_apply(op_i, chc_q, wdata_i, CHC_WMASK);
    if (srst)     chc_d = '0;

    flag_d = flag_q;
    if (wr_stat_i) flag_d = NUM_CH'(alias_apply(op_i, 32'(flag_q), wdata_i, CH_MASK));
    flag_d = flag_d | done_i;
    if (srst)      flag_d = '0;
  end

  assign ctrl_en = wr_ctrl_i | srst;
  assign chc_en  = wr_chc_i | srst;
  assign flag_en = wr_stat_i | (|done_i) | srst;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chc_q <= '0;
    end else if (chc_en) begin
      chc_q <= chc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  // read values and outputs
  always_comb begin
    stat_rd_o                           = '0;
    stat_rd_o[STAT_KEY_BIT]             = key_ready_i;
    stat_rd_o[STAT_ACT_LO +: NUM_CH]    = active_i;
    stat_rd_o[STAT_RDY_LO +: NUM_CH]    = ready_i;
    stat_rd_o[NUM_CH-1:0]               = flag_q;
  end

  assign ctrl_rd_o = ctrl_q | CAP_BITS;
  assign chc_rd_o  = chc_q;
  assign srst_o    = srst;
  assign gate_o    = ctrl_q[CTRL_GATE_BIT];
  assign mode_o    = ctrl_q[CTRL_MODE_LO +: 3];
  assign ch_en_o   = chc_q[NUM_CH-1:0];
  assign ch_prio_o = chc_q[CHC_PRIO_LO +: NUM_CH];
  assign irq_o     = flag_q & ctrl_q[NUM_CH-1:0];

  // R5: soft reset empties channel control on the following edge
  p_srst_clears_chc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (chc_q == '0));

  // R6: a completion outside soft reset leaves its flag set
  p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_i != '0) && !srst) |=> ((flag_q & $past(done_i)) == $past(done_i)));

  // R6: flags only drop through a software access or soft reset
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat_i && !srst) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

endmodule

// File: rtl/chreg_chan.sv
module chreg_chan
  import chreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst_i,
  input  logic        wr_i,
  input  logic [1:0]  kind_i,
  input  alias_op_e   op_i,
  input  logic [31:0] wdata_i,
  input  logic        evt_we_i,
  input  logic [31:0] evt_bits_i,
  input  logic        sem_dec_i,
  output logic [31:0] rd_o
);

  localparam logic [31:0] SEM_WMASK = (32'd1 << SEM_W) - 32'd1;

  logic [31:0]      ptr_q, ptr_d;
  logic [SEM_W-1:0] sem_q, sem_d;
  logic [31:0]      cst_q, cst_d;
  logic [31:0]      opt_q, opt_d;
  logic             wr_ptr, wr_sem, wr_cst, wr_opt;
  logic             ptr_en, sem_en, cst_en, opt_en;

  assign wr_ptr = wr_i && (kind_i == KIND_PTR);
  assign wr_sem = wr_i && (kind_i == KIND_SEM);
  assign wr_cst = wr_i && (kind_i == KIND_STS);
  assign wr_opt = wr_i && (kind_i == KIND_OPT);

  // next state
  always_comb begin
    ptr_d = ptr_q;
    if (wr_ptr) ptr_d = alias_apply(op_i, ptr_q, wdata_i, '1);

    sem_d = sem_q;
    if (wr_sem) sem_d = SEM_W'(alias_apply(op_i, 32'(sem_q), wdata_i, SEM_WMASK));
    if (sem_dec_i && (sem_d != '0)) sem_d = sem_d - SEM_W'(1);

    cst_d = cst_q;
    if (wr_cst)   cst_d = alias_apply(op_i, cst_q, wdata_i, CST_WMASK);
    if (evt_we_i) cst_d = cst_d | (evt_bits_i & CST_WMASK);

    opt_d = opt_q;
    if (wr_opt) opt_d = alias_apply(op_i, opt_q, wdata_i, '1);

    if (srst_i) begin
      ptr_d = '0;
      sem_d = '0;
      cst_d = '0;
      opt_d = '0;
    end
  end

  assign ptr_en = wr_ptr | srst_i;
  assign sem_en = wr_sem | sem_dec_i | srst_i;
  assign cst_en = wr_cst | evt_we_i | srst_i;
  assign opt_en = wr_opt | srst_i;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sem_q <= '0;
    end else if (sem_en) begin
      sem_q <= sem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst_q <= '0;
    end else if (cst_en) begin
      cst_q <= cst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q <= '0;
    end else if (opt_en) begin
      opt_q <= opt_d;
    end
  end

  // read select
  always_comb begin
    unique case (kind_i)
      KIND_PTR: rd_o = ptr_q;
      KIND_SEM: rd_o = 32'(sem_q);
      KIND_STS: rd_o = cst_q;
      default:  rd_o = opt_q;
    endcase
  end

  // R11: an empty semaphore stays empty under a decrement alone
  p_sem_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sem_q == '0) && sem_dec_i && !wr_sem) |=> (sem_q == '0));

  // R10: event bits are present in the status register after the strobe
  p_evt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_we_i && !srst_i) |=>
      ((cst_q & ($past(evt_bits_i) & CST_WMASK)) == ($past(evt_bits_i) & CST_WMASK)));

  // R5: soft reset empties every channel register
  p_srst_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> ((ptr_q == '0) && (sem_q == '0) && (cst_q == '0) && (opt_q == '0)));

endmodule

// File: rtl/chreg_bank.sv
module chreg_bank
  import chreg_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned ADDR_W     = 12,
  parameter bit          CAP_CIPHER = 1'b1,
  parameter bit          CAP_HASH   = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_CH-1:0]        done_i,
  input  logic [NUM_CH-1:0]        ready_i,
  input  logic [NUM_CH-1:0]        active_i,
  input  logic                     key_ready_i,
  input  logic [NUM_CH-1:0]        evt_we_i,
  input  logic [NUM_CH*WORD_W-1:0] evt_bits_i,
  input  logic [NUM_CH-1:0]        sem_dec_i,
  output logic [NUM_CH-1:0]        irq_o,
  output logic [NUM_CH-1:0]        ch_en_o,
  output logic [NUM_CH-1:0]        ch_prio_o,
  output logic                     soft_rst_o,
  output logic                     clk_gate_o,
  output logic [2:0]               mode_o
);

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  alias_op_e         op;
  logic              hit_ctrl, hit_stat, hit_chc, hit_any;
  logic [NUM_CH-1:0] hit_ch;
  logic [1:0]        kind;
  logic              wr;
  logic [31:0]       ctrl_rd, stat_rd, chc_rd;
  logic [31:0]       ch_rd [NUM_CH];
  logic              srst;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  assign wr = bus_sel & bus_wr;

  chreg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .addr_i     (bus_addr),
    .op_o       (op),
    .hit_ctrl_o (hit_ctrl),
    .hit_stat_o (hit_stat),
    .hit_chc_o  (hit_chc),
    .hit_ch_o   (hit_ch),
    .kind_o     (kind),
    .hit_any_o  (hit_any)
  );

  chreg_global #(.NUM_CH(NUM_CH), .CAP_CIPHER(CAP_CIPHER), .CAP_HASH(CAP_HASH)) u_global (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_ctrl_i   (wr & hit_ctrl),
    .wr_stat_i   (wr & hit_stat),
    .wr_chc_i    (wr & hit_chc),
    .op_i        (op),
    .wdata_i     (bus_wdata),
    .done_i      (done_i),
    .ready_i     (ready_i),
    .active_i    (active_i),
    .key_ready_i (key_ready_i),
    .ctrl_rd_o   (ctrl_rd),
    .stat_rd_o   (stat_rd),
    .chc_rd_o    (chc_rd),
    .srst_o      (srst),
    .gate_o      (clk_gate_o),
    .mode_o      (mode_o),
    .ch_en_o     (ch_en_o),
    .ch_prio_o   (ch_prio_o),
    .irq_o       (irq_o)
  );

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
    chreg_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .srst_i     (srst),
      .wr_i       (wr & hit_ch[gc]),
      .kind_i     (kind),
      .op_i       (op),
      .wdata_i    (bus_wdata),
      .evt_we_i   (evt_we_i[gc]),
      .evt_bits_i (evt_bits_i[gc*WORD_W +: WORD_W]),
      .sem_dec_i  (sem_dec_i[gc]),
      .rd_o       (ch_rd[gc])
    );
  end

  // read multiplexer, one-hot selects
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (hit_ctrl) bus_rdata = bus_rdata | ctrl_rd;
      if (hit_stat) bus_rdata = bus_rdata | stat_rd;
      if (hit_chc)  bus_rdata = bus_rdata | chc_rd;
      for (int i = 0; i < NUM_CH; i++) begin
        if (hit_ch[i]) bus_rdata = bus_rdata | ch_rd[i];
      end
    end
  end

  assign soft_rst_o = srst;

  // R3: unmapped offsets read as zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_sel && !bus_wr && !hit_any) |-> (bus_rdata == '0));

  // R4: capability bits read back as the parameters
  p_caps_ro_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_sel && !bus_wr && hit_ctrl) |-> (bus_rdata[29:28] == {CAP_CIPHER, CAP_HASH}));

  // R2: only one register answers at a time
  p_onehot_hit_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_sel |-> $onehot0({hit_ctrl, hit_stat, hit_chc, hit_ch}));

endmodule

// File: tb/test_chreg_bank.sv
`timescale 1ns/1ps
module test_chreg_bank;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_sel, bus_wr;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [3:0]   done_i, ready_i, active_i, evt_we_i, sem_dec_i;
  logic         key_ready_i;
  logic [127:0] evt_bits_i;
  logic [3:0]   irq_o, ch_en_o, ch_prio_o;
  logic         soft_rst_o, clk_gate_o;
  logic [2:0]   mode_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  logic [31:0] mdl [19];

  always #2 clk = ~clk;

  chreg_bank i_chreg_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_i(done_i), .ready_i(ready_i), .active_i(active_i),
    .key_ready_i(key_ready_i), .evt_we_i(evt_we_i), .evt_bits_i(evt_bits_i),
    .sem_dec_i(sem_dec_i), .irq_o(irq_o), .ch_en_o(ch_en_o),
    .ch_prio_o(ch_prio_o), .soft_rst_o(soft_rst_o), .clk_gate_o(clk_gate_o),
    .mode_o(mode_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  function automatic logic [11:0] reg_addr(input int idx);
    if (idx < 3) return 12'(idx * 16);
    return 12'(256 + ((idx - 3) / 4) * 64 + ((idx - 3) % 4) * 16);
  endfunction

  function automatic logic [31:0] reg_mask(input int idx);
    case (idx)
      0: return 32'hC0E0_000F;
      1: return 32'h0000_000F;
      2: return 32'h0001_0F0F;
      default: begin
        case ((idx - 3) % 4)
          1: return 32'h0000_00FF;
          2: return 32'h00FF_007E;
          default: return 32'hFFFF_FFFF;
        endcase
      end
    endcase
  endfunction

  function automatic logic [31:0] ro_bits(input int idx);
    if (idx == 0) return 32'h3000_0000;
    if (idx == 1) return (32'(key_ready_i) << 28) | (32'(active_i) << 24) | (32'(ready_i) << 16);
    return 32'h0;
  endfunction

  function automatic logic [31:0] apply(input int op, input logic [31:0] cur,
                                        input logic [31:0] wd, input logic [31:0] m);
    logic [31:0] r;
    case (op)
      0: r = wd;
      1: r = cur | wd;
      2: r = cur & ~wd;
      default: r = cur ^ wd;
    endcase
    return (r & m) | (cur & ~m);
  endfunction

  task automatic verify_all(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 19; i++) begin
      bus_read(reg_addr(i), v);
      chk(tag, v, mdl[i] | ro_bits(i));
    end
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    pats[0] = 32'hA5A5_A5A5; pats[1] = 32'h5A5A_5A5A;
    pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h0F0F_00F1;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    done_i = '0; evt_we_i = '0; sem_dec_i = '0; evt_bits_i = '0;
    ready_i = 4'h5; active_i = 4'h2; key_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 19; i++) mdl[i] = '0;
    mdl[0] = 32'hC000_0000;
    bus_read(12'h000, v);
    chk("R1 ctrl reset", v, 32'hF000_0000);
    chk("R1 soft_rst_o", 32'(soft_rst_o), 32'd1);
    chk("R1 clk_gate_o", 32'(clk_gate_o), 32'd1);
    chk("R1 irq_o", 32'(irq_o), 32'd0);
    verify_all("R1 reset value");

    // R5: release soft reset through the clear alias
    bus_write(12'h008, 32'hC000_0000);
    mdl[0] = 32'h0;
    chk("R5 released", 32'(soft_rst_o), 32'd0);

    // R2 R3 R9 R7 R8 R12: every register, every access type, several patterns
    for (int i = 0; i < 19; i++) begin
      for (int op = 0; op < 4; op++) begin
        for (int p = 0; p < 4; p++) begin
          logic [31:0] wd;
          wd = pats[p];
          if (i == 0) wd = wd & 32'h7FFF_FFFF;
          bus_write(reg_addr(i) | 12'(op * 4), wd);
          mdl[i] = apply(op, mdl[i], wd, reg_mask(i));
          for (int a = 0; a < 4; a++) begin
            bus_read(reg_addr(i) | 12'(a * 4), v);
            if (a == 0) chk(i > 2 ? "R9 R2 channel register" : "R2 global register", v, mdl[i] | ro_bits(i));
            else        chk("R3 alias read", v, mdl[i] | ro_bits(i));
          end
          chk("R7 irq_o", 32'(irq_o), mdl[1][3:0] & mdl[0][3:0]);
          chk("R8 ch_en_o", 32'(ch_en_o), 32'(mdl[2][3:0]));
          chk("R8 ch_prio_o", 32'(ch_prio_o), 32'(mdl[2][11:8]));
          chk("R12 clk_gate_o", 32'(clk_gate_o), 32'(mdl[0][30]));
          chk("R12 mode_o", 32'(mode_o), 32'(mdl[0][23:21]));
        end
      end
    end

    // R3: unmapped reads are zero, unmapped writes change nothing
    for (int w = 0; w < 1024; w++) begin
      logic [11:0] a;
      a = 12'(w * 4);
      if (!((a < 12'h030) || (a >= 12'h100 && a < 12'h200))) begin
        bus_read(a, v);
        chk("R3 unmapped read", v, 32'h0);
      end
    end
    bus_write(12'h030, 32'hFFFF_FFFF);
    bus_write(12'h0FC, 32'hFFFF_FFFF);
    bus_write(12'h200, 32'hFFFF_FFFF);
    bus_write(12'hFFC, 32'hFFFF_FFFF);
    verify_all("R3 unmapped write");

    // R4: read-only status fields follow inputs, ignore writes
    ready_i = 4'hA; active_i = 4'h1; key_ready_i = 1'b0;
    bus_write(12'h010, 32'hFFFF_FFFF);
    mdl[1] = 32'hF;
    bus_read(12'h010, v);
    chk("R4 status read-only", v, 32'h010A_000F);
    bus_write(12'h01C, 32'hFFFF_FFFF);
    mdl[1] = 32'h0;
    bus_read(12'h014, v);
    chk("R4 status toggle", v, 32'h010A_0000);
    bus_write(12'h004, 32'h3000_0000);
    bus_write(12'h008, 32'h3000_0000);
    bus_read(12'h000, v);
    chk("R4 caps read-only", v, mdl[0] | 32'h3000_0000);

    // R6 R7: completion flags and interrupt gating
    bus_write(12'h000, 32'h0000_0004);
    mdl[0] = 32'h4;
    @(negedge clk); done_i = 4'h4;
    @(negedge clk); done_i = 4'h0;
    bus_read(12'h010, v);
    chk("R6 done sets flag", v & 32'hF, 32'h4);
    chk("R7 irq on", 32'(irq_o), 32'h4);
    repeat (3) @(negedge clk);
    bus_read(12'h010, v);
    chk("R6 flag sticky", v & 32'hF, 32'h4);
    bus_write(12'h008, 32'h0000_0004);
    chk("R7 irq masked", 32'(irq_o), 32'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h018; bus_wdata = 32'h4; done_i = 4'h4;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; done_i = 4'h0;
    bus_read(12'h010, v);
    chk("R6 done beats clear", v & 32'hF, 32'h4);
    bus_write(12'h018, 32'h4);
    bus_read(12'h010, v);
    chk("R6 software clear", v & 32'hF, 32'h0);

    // R10: status events on channel 1
    bus_write(12'h160, 32'h0);
    @(negedge clk); evt_we_i = 4'h2; evt_bits_i = {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0};
    @(negedge clk); evt_we_i = 4'h0; evt_bits_i = '0;
    bus_read(12'h160, v);
    chk("R10 event masked", v, 32'h00FF_007E);
    bus_write(12'h168, 32'h0000_0006);
    bus_read(12'h16C, v);
    chk("R10 event clear", v, 32'h00FF_0078);
    mdl[9] = 32'h00FF_0078;

    // R11: semaphore decrement on channel 3
    bus_write(12'h1D0, 32'h2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sem_dec_i = 4'h8;
      @(negedge clk); sem_dec_i = 4'h0;
      bus_read(12'h1D0, v);
      chk("R11 semaphore decrement", v, (k == 0) ? 32'h1 : 32'h0);
    end
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h1D0; bus_wdata = 32'h5; sem_dec_i = 4'h8;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; sem_dec_i = 4'h0;
    bus_read(12'h1D0, v);
    chk("R11 write with decrement", v, 32'h4);

    // R5: soft reset hold and release
    bus_write(12'h100, 32'h1234_5678);
    bus_write(12'h020, 32'h0000_000F);
    bus_write(12'h004, 32'h8000_0000);
    @(negedge clk);
    chk("R5 soft_rst_o", 32'(soft_rst_o), 32'd1);
    chk("R5 ch_en_o held", 32'(ch_en_o), 32'h0);
    bus_read(12'h100, v);
    chk("R5 pointer held", v, 32'h0);
    bus_read(12'h000, v);
    chk("R5 ctrl low bits held", v, 32'hB000_0000);
    bus_write(12'h100, 32'h0000_FFFF);
    bus_read(12'h100, v);
    chk("R5 write lost", v, 32'h0);
    bus_write(12'h008, 32'hC000_0000);
    bus_read(12'h000, v);
    chk("R5 ctrl after release", v, 32'h3000_0000);
    bus_read(12'h1D0, v);
    chk("R5 semaphore reset", v, 32'h0);
    bus_write(12'h100, 32'h0000_ABCD);
    bus_read(12'h100, v);
    chk("R5 write after release", v, 32'h0000_ABCD);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule